// File: doc/BRIEF.md
# Inter-VM Doorbell Register Window

This block is the 32-bit control window of a shared-memory peer device. Software sees a 256-byte region with four word registers: an interrupt enable mask, an interrupt cause word that clears when read, a read-only word holding this device's peer number, and a write-only doorbell. Writing the doorbell sends a notification to another peer. The write names the target peer and a vector. The block does not raise a local interrupt for it; it emits a one-cycle outbound message on its own port.

Notifications that arrive from other peers come in on an inbound port. Each one marks a pending bit for its vector and sets bit 0 of the cause word. The interrupt line is a level. It is high whenever the cause word and the mask share a set bit. The peer number is loaded by the fabric that assigns it, through a dedicated load strobe. Until that load happens, the position word reads zero.

The register bus takes one request per cycle and answers each read one cycle later. The outbound and inbound notification ports have no ready signal and no back-pressure. The outbound sink must accept a message in every cycle in which `out_valid` is high. The inbound source may present a message in any cycle, and every message presented is taken.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset, the mask, cause and position words read zero, and `irq`, `out_valid` and every `pend_vec` bit are low.
- R2: A read request yields `rsp_valid` high with `rsp_rdata` in the next cycle. The word map is: mask at byte offset 0x00, cause at 0x04, position at 0x08, doorbell at 0x0C.
- R3: Any 32-bit value written to the mask word reads back unchanged.
- R4: A write to the cause word loads the written value. A read of the cause word returns its value and clears it, so an immediate second read returns zero.
- R5: The position word returns the value last loaded through `id_load`/`id_value`, zero-extended. Bus writes to offset 0x08 do not change it.
- R6: A read of the doorbell returns zero. It raises no outbound message and leaves the cause word unchanged.
- R7: A doorbell write whose bits 15:0 are below NVEC raises `out_valid` for exactly one cycle, starting the cycle after the write. In that cycle `out_peer` holds bits 31:16 and `out_vec` holds bits 15:0 of the written word.
- R8: A doorbell write whose bits 15:0 are NVEC or more raises no outbound message.
- R9: An inbound message on vector v sets `pend_vec[v]` and cause bit 0 in the next cycle. A cause read clears all pending bits. A message that arrives in the same cycle as a cause read is kept after the clear.
- R10: `irq` is high exactly when the cause word and the mask have a common set bit. It follows a change of either word one cycle after the request or message that caused the change.
- R11: A read of any other offset in the window, including an offset that is not word-aligned, returns zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the 256-byte window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| id_load | input | 1 | Load strobe for the assigned peer number |
| id_value | input | ID_W | Assigned peer number |
| in_valid | input | 1 | Inbound notification from a peer |
| in_vec | input | VEC_W | Vector of the inbound notification |
| out_valid | output | 1 | Outbound notification, one cycle per doorbell write |
| out_peer | output | ID_W | Destination peer of the outbound notification |
| out_vec | output | VEC_W | Vector of the outbound notification |
| pend_vec | output | NVEC | Per-vector pending bits |
| irq | output | 1 | Level interrupt |

## Verification
Every result of this block has a latency of one register stage. Read data, the outbound message, a pending bit and the updated cause word all appear in the cycle after the request or message that produced them, and `irq` follows from those registered words in that same cycle. The bench drives a stimulus on one falling edge, removes it on the next falling edge, and samples there, which is one rising edge later. For the one-cycle outbound pulse, the bench also samples at the falling edge after that, where the pulse must have ended. The same-cycle case of a cause read and an inbound message is driven on a single falling edge. This checks both the returned old value and the message that must survive the clear.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned WIN_AW   = 8;
  localparam int unsigned VFIELD_W = 16;

  localparam logic [WIN_AW-1:0] OFS_MASK = 8'h00;
  localparam logic [WIN_AW-1:0] OFS_CAUSE = 8'h04;
  localparam logic [WIN_AW-1:0] OFS_POS  = 8'h08;
  localparam logic [WIN_AW-1:0] OFS_BELL = 8'h0C;

  typedef enum logic [2:0] {
    SEL_MASK, SEL_CAUSE, SEL_POS, SEL_BELL, SEL_NONE
  } sel_e;

  typedef struct packed {
    logic wr_mask;
    logic wr_cause;
    logic wr_bell;
    logic rd_cause;
    logic rd_any;
    sel_e rsel;
  } dec_t;
endpackage

// File: rtl/pdb_decode.sv
module pdb_decode
  import pdb_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_AW-1:0] req_addr,
  output dec_t              dec
);
  sel_e hit;

  always_comb begin
    case (req_addr)
      OFS_MASK:  hit = SEL_MASK;
      OFS_CAUSE: hit = SEL_CAUSE;
      OFS_POS:   hit = SEL_POS;
      OFS_BELL:  hit = SEL_BELL;
      default:   hit = SEL_NONE;
    endcase
  end

  always_comb begin
    dec          = '0;
    dec.rsel     = hit;
    dec.wr_mask  = req_valid && req_write && (hit == SEL_MASK);
    dec.wr_cause = req_valid && req_write && (hit == SEL_CAUSE);
    dec.wr_bell  = req_valid && req_write && (hit == SEL_BELL);
    dec.rd_cause = req_valid && !req_write && (hit == SEL_CAUSE);
    dec.rd_any   = req_valid && !req_write;
  end
endmodule

// File: rtl/pdb_doorbell.sv
module pdb_doorbell
  import pdb_pkg::*;
#(
  parameter int unsigned NVEC  = 4,
  parameter int unsigned ID_W  = 16,
  parameter int unsigned VEC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_bell,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_peer,
  output logic [VEC_W-1:0]  out_vec
);
  logic [VFIELD_W-1:0] vfield;
  logic                in_range;

  assign vfield   = wdata[VFIELD_W-1:0];
  assign in_range = (32'(vfield) < NVEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_peer  <= '0;
      out_vec   <= '0;
    end else begin
      out_valid <= wr_bell && in_range;
      if (wr_bell && in_range) begin
        out_peer <= wdata[VFIELD_W +: ID_W];
        out_vec  <= vfield[VEC_W-1:0];
      end
    end
  end

  // R7
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(wr_bell));

  // R8
  out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bell && !in_range) |=> !out_valid);
endmodule

// File: rtl/pdb_notify.sv
module pdb_notify
  import pdb_pkg::*;
#(
  parameter int unsigned NVEC  = 4,
  parameter int unsigned VEC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cause,
  input  logic              rd_cause,
  input  logic [DATA_W-1:0] wdata,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_vec,
  output logic [DATA_W-1:0] cause_q,
  output logic [NVEC-1:0]   pend_q
);
  logic              in_ok;
  logic [DATA_W-1:0] cause_nx;
  logic [NVEC-1:0]   pend_nx;

  assign in_ok = in_valid && (32'(in_vec) < NVEC);

  always_comb begin
    cause_nx = cause_q;
    pend_nx  = pend_q;
    if (wr_cause)      cause_nx = wdata;
    else if (rd_cause) cause_nx = '0;
    if (rd_cause)      pend_nx  = '0;
    if (in_ok) begin
      cause_nx[0]     = 1'b1;
      pend_nx[in_vec] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      pend_q  <= '0;
    end else begin
      cause_q <= cause_nx;
      pend_q  <= pend_nx;
    end
  end

  // R4
  cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && !in_valid) |=> (cause_q == '0 && pend_q == '0));

  // R9
  in_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ok |=> cause_q[0]);
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import pdb_pkg::*;
#(
  parameter int unsigned NVEC  = 4,
  parameter int unsigned ID_W  = 16,
  localparam int unsigned VEC_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_AW-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              id_load,
  input  logic [ID_W-1:0]   id_value,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_vec,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_peer,
  output logic [VEC_W-1:0]  out_vec,
  output logic [NVEC-1:0]   pend_vec,
  output logic              irq
);
  dec_t              dec;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] cause_q;
  logic [ID_W-1:0]   pos_q;

  pdb_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .dec       (dec)
  );

  pdb_doorbell #(.NVEC(NVEC), .ID_W(ID_W), .VEC_W(VEC_W)) u_bell (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_bell   (dec.wr_bell),
    .wdata     (req_wdata),
    .out_valid (out_valid),
    .out_peer  (out_peer),
    .out_vec   (out_vec)
  );

  pdb_notify #(.NVEC(NVEC), .VEC_W(VEC_W)) u_ntf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cause (dec.wr_cause),
    .rd_cause (dec.rd_cause),
    .wdata    (req_wdata),
    .in_valid (in_valid),
    .in_vec   (in_vec),
    .cause_q  (cause_q),
    .pend_q   (pend_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pos_q  <= '0;
    end else begin
      if (dec.wr_mask) mask_q <= req_wdata;
      if (id_load)     pos_q  <= id_value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= dec.rd_any;
      if (dec.rd_any) begin
        case (dec.rsel)
          SEL_MASK:  rsp_rdata <= mask_q;
          SEL_CAUSE: rsp_rdata <= cause_q;
          SEL_POS:   rsp_rdata <= DATA_W'(pos_q);
          default:   rsp_rdata <= '0;
        endcase
      end else begin
        rsp_rdata <= '0;
      end
    end
  end

  assign irq = |(mask_q & cause_q);

  // R2
  rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(id_load) |-> $stable(pos_q));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq)) |-> $past(in_valid || dec.wr_mask || dec.wr_cause));
endmodule

// File: tb/peer_doorbell_regs_tb.sv
module peer_doorbell_regs_tb;
  localparam int NVEC = 4;
  localparam int ID_W = 16;
  localparam int VEC_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic id_load = 1'b0;
  logic [ID_W-1:0] id_value = '0;
  logic in_valid = 1'b0;
  logic [VEC_W-1:0] in_vec = '0;
  logic out_valid;
  logic [ID_W-1:0] out_peer;
  logic [VEC_W-1:0] out_vec;
  logic [NVEC-1:0] pend_vec;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  peer_doorbell_regs #(.NVEC(NVEC), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .id_load(id_load), .id_value(id_value),
    .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_peer(out_peer), .out_vec(out_vec),
    .pend_vec(pend_vec), .irq(irq)
  );

  // Table: is_read, offset, data, requirement number
  localparam int NT = 16;
  localparam logic       T_RD   [NT] = '{0,1, 0,1,1, 0,1, 0,1,1, 0,1, 0,1,1,1};
  localparam logic [7:0] T_ADDR [NT] = '{8'h00, 8'h00, 8'h04, 8'h04, 8'h04,
                                         8'h00, 8'h00, 8'h04, 8'h04, 8'h04,
                                         8'h08, 8'h08, 8'h40, 8'h40, 8'h02, 8'h0C};
  localparam logic [31:0] T_DAT [NT] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                         32'h1, 32'h1, 32'h0,
                                         32'h0000_A5A5, 32'h0000_A5A5,
                                         32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0,
                                         32'h1234_5678, 32'h0,
                                         32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0};
  // R3 rows 0-1 and 5-6, R4 rows 2-4 and 7-9, R5 rows 10-11, R11 rows 12-14, R6 row 15
  localparam int T_REQ [NT] = '{3,3, 4,4,4, 3,3, 4,4,4, 5,5, 11,11,11, 6};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic inbound(input logic [VEC_W-1:0] v);
    @(negedge clk);
    in_valid = 1; in_vec = v;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1", {31'b0, irq}, 32'h0, "irq after reset");
    chk("R1", {31'b0, out_valid}, 32'h0, "out_valid after reset");
    chk("R1", 32'(pend_vec), 32'h0, "pending after reset");
    bus_rd(8'h00, d, v); chk("R1", d, 32'h0, "mask after reset");
    chk("R2", {31'b0, v}, 32'h1, "rsp_valid on read");
    bus_rd(8'h04, d, v); chk("R1", d, 32'h0, "cause after reset");
    bus_rd(8'h08, d, v); chk("R1", d, 32'h0, "position after reset");

    for (int i = 0; i < NT; i++) begin
      if (T_RD[i]) begin
        bus_rd(T_ADDR[i], d, v);
        n_chk++;
        if (d !== T_DAT[i] || v !== 1'b1) begin
          n_fail++;
          $display("FAIL R%0d row %0d: actual %h expected %h", T_REQ[i], i, d, T_DAT[i]);
        end
      end else begin
        bus_wr(T_ADDR[i], T_DAT[i]);
      end
    end
    // R6 doorbell read raised nothing
    chk("R6", {31'b0, out_valid}, 32'h0, "out_valid after doorbell read");
    bus_rd(8'h04, d, v); chk("R6", d, 32'h0, "cause after doorbell read");

    // R5 position load, then write ignored
    @(negedge clk); id_load = 1; id_value = 16'h0007;
    @(negedge clk); id_load = 0; id_value = 16'hFFFF;
    bus_rd(8'h08, d, v); chk("R5", d, 32'h7, "position after load");
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_rd(8'h08, d, v); chk("R5", d, 32'h7, "position after bus write");

    // R7 doorbell in range
    bus_wr(8'h0C, 32'h0003_0002);
    chk("R7", {31'b0, out_valid}, 32'h1, "out_valid after doorbell");
    chk("R7", 32'(out_peer), 32'h3, "out_peer");
    chk("R7", 32'(out_vec), 32'h2, "out_vec");
    @(negedge clk);
    chk("R7", {31'b0, out_valid}, 32'h0, "out_valid one cycle only");

    // R8 out of range vectors
    bus_wr(8'h0C, 32'h0005_0004);
    chk("R8", {31'b0, out_valid}, 32'h0, "vector == NVEC dropped");
    bus_wr(8'h0C, 32'h0005_8001);
    chk("R8", {31'b0, out_valid}, 32'h0, "vector 0x8001 dropped");

    // R9 / R10 inbound with mask 0xA5A5 (bit 0 set)
    inbound(2'd3);
    chk("R9", 32'(pend_vec), 32'h8, "pending after vector 3");
    chk("R10", {31'b0, irq}, 32'h1, "irq with mask bit 0");
    bus_rd(8'h04, d, v); chk("R9", d, 32'h1, "cause bit 0 from inbound");
    chk("R9", 32'(pend_vec), 32'h0, "pending cleared by cause read");
    chk("R10", {31'b0, irq}, 32'h0, "irq after cause cleared");

    bus_wr(8'h00, 32'h0);
    inbound(2'd1);
    chk("R9", 32'(pend_vec), 32'h2, "pending after vector 1");
    chk("R10", {31'b0, irq}, 32'h0, "irq masked");

    // R9 inbound in the same cycle as cause read
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h04;
    in_valid = 1; in_vec = 2'd2;
    @(negedge clk);
    req_valid = 0; in_valid = 0;
    chk("R9", rsp_rdata, 32'h1, "read returns old cause");
    chk("R9", 32'(pend_vec), 32'h4, "same-cycle inbound kept in pending");
    bus_rd(8'h04, d, v); chk("R9", d, 32'h1, "same-cycle inbound kept in cause");
    bus_rd(8'h04, d, v); chk("R4", d, 32'h0, "second cause read");

    // R10 mask and cause overlap
    bus_wr(8'h00, 32'h2);
    bus_wr(8'h04, 32'h2);
    chk("R10", {31'b0, irq}, 32'h1, "irq on overlap");
    bus_wr(8'h04, 32'h1);
    chk("R10", {31'b0, irq}, 32'h0, "irq without overlap");

    summary();
  end
endmodule